// File: doc/BRIEF.md
# Lane-Splittable Signed Multiply-Accumulate Unit

This block multiplies two 32-bit signed operand words and accumulates the result, with the operand width chosen per operation. One selection makes a single 32x32 multiply feeding a 64-bit accumulator. Another splits both words into two independent 16x16 lanes, each with a 32-bit accumulator. A third splits them into four independent 8x8 lanes, each with a 16-bit accumulator. All data is two's complement. In every mode the accumulators are packed into one 64-bit output word, with lane k at bit offset k times twice the lane width.

The multiplier is one radix-4 Booth partial-product array built from 16 rows. Each row is generated for the lane width in use. Sign extension is compressed into one inverted sign bit per row, and the fixed correction for all rows is folded into the first row of each lane. The +1 correction of a negated row sits in a free low column of the next row. The top row of each lane is formed as an exact negation, so the array has no extra row. Row bits outside their lane's field are masked off, and the final carry-save-free summation and the accumulate adder both kill carries at lane boundaries.

The datapath has two stages. An issue register holds the accepted operation, and its control has two states: ST_EMPTY, where nothing is held, and ST_LOADED, where an accepted operation waits to be accumulated. The transition into ST_LOADED or a stay there is taken on an accepted operation without clear. The transition to ST_EMPTY is taken on no operation or on clear. An operation presented at rising edge n writes the accumulator at edge n+1.

Top module: `simd_mac`

## Requirements
- R1: After reset, acc_out is zero.
- R2: With mode 2'b00 and acc_en low, an operation accepted at edge n loads acc_out at edge n+1 with the 64-bit signed product of opa and opb.
- R3: With mode 2'b01, lane k (k = 0, 1) of acc_out, bits [32k+31:32k], receives the signed product of opa[16k+15:16k] and opb[16k+15:16k].
- R4: With mode 2'b10, lane k (k = 0..3) of acc_out, bits [16k+15:16k], receives the signed product of opa[8k+7:8k] and opb[8k+7:8k].
- R5: In the split modes, operand values in one lane, including the most negative values -128 and -32768, do not change any other lane's result.
- R6: With acc_en high, each lane adds its new product to its own accumulator modulo 2 to the power of its accumulator width, with no carry into the next lane.
- R7: A clear at edge n sets acc_out to zero at that edge and discards any operation that is held for that edge or presented with the clear.
- R8: When no operation was accepted at the previous edge, acc_out holds its value, whatever opa, opb, mode and acc_en do.
- R9: Mode 2'b11 behaves as mode 2'b00.
- R10: The mode and acc_en are captured with each operation, so back-to-back operations in different modes each use their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accepts the operation on the operand inputs at this edge |
| clear | input | 1 | Synchronous clear of all accumulators, highest priority |
| acc_en | input | 1 | High adds the product to the accumulator, low loads the product |
| mode | input | 2 | 00 one 32-bit lane, 01 two 16-bit lanes, 10 four 8-bit lanes, 11 as 00 |
| opa | input | 32 | Multiplicand word, lanes packed from bit 0 |
| opb | input | 32 | Booth-recoded multiplier word, lanes packed from bit 0 |
| acc_out | output | 64 | Packed lane accumulators |

## Verification
Each mode is driven with random operand words and with the extreme values -128, -32768 and -2^31 on both inputs, since those drive the doubled negative Booth multiple and the top-row negation to full range. Patterns that place the extreme value in one lane and zero or ones in the others show whether a carry or partial-product bit leaks across a lane boundary. Repeated accumulation of the largest products tells lane-local wrap apart from carry into the neighbour. Clear while an operation is held, idle cycles with moving inputs, the reserved mode and back-to-back mode changes show that control is captured per operation.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

    localparam int DATA_W  = 32;
    localparam int ACC_W   = 2 * DATA_W;
    localparam int NDIG    = DATA_W / 2;
    localparam int MIN_LW  = 8;
    localparam int SEG_W   = 2 * MIN_LW;
    localparam int NSEG    = ACC_W / SEG_W;

    typedef enum logic [1:0] {
        MODE_X32 = 2'b00,
        MODE_X16 = 2'b01,
        MODE_X8  = 2'b10,
        MODE_RSV = 2'b11
    } mac_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } pipe_state_e;

    // Lane width in bits for a mode code.
    function automatic int lane_bits(input logic [1:0] m);
        case (m)
            MODE_X16: return DATA_W / 2;
            MODE_X8:  return DATA_W / 4;
            default:  return DATA_W;
        endcase
    endfunction

    // Ones over one product field (twice the lane width).
    function automatic logic [ACC_W-1:0] field_ones(input int lw);
        if (2 * lw >= ACC_W)
            return '1;
        return (ACC_W'(1) << (2 * lw)) - ACC_W'(1);
    endfunction

    // Constant that cancels the inverted sign bits of all rows of one lane.
    function automatic logic [ACC_W-1:0] sext_const(input int lw);
        logic [ACC_W-1:0] s;
        int nd;
        nd = lw / 2;
        s  = '0;
        for (int j = 0; j < nd - 1; j++)
            s = s + (ACC_W'(1) << (lw + 2 * j));
        s = s + (ACC_W'(1) << (lw + 1 + 2 * (nd - 1)));
        return (~s + ACC_W'(1)) & field_ones(lw);
    endfunction

endpackage

// File: rtl/smac_booth_array.sv
module smac_booth_array
    import simd_mac_pkg::*;
(
    input  logic [DATA_W-1:0]            a,
    input  logic [DATA_W-1:0]            b,
    input  logic [1:0]                   mode,
    output logic [NDIG-1:0][ACC_W-1:0]   rows
);

    logic [DATA_W:0] b_ext;
    assign b_ext = {b, 1'b0};

    always_comb begin
        int               lw;
        int               ndl;
        logic [ACC_W-1:0] ones_l;
        logic [ACC_W-1:0] fmask;
        logic [ACC_W-1:0] cst;
        logic             hot_prev;
        lw       = lane_bits(mode);
        ndl      = lw / 2;
        ones_l   = (ACC_W'(1) << lw) - ACC_W'(1);
        fmask    = field_ones(lw);
        cst      = sext_const(lw);
        hot_prev = 1'b0;
        rows     = '0;
        for (int i = 0; i < NDIG; i++) begin
            int               k;
            int               j;
            int               base;
            logic [ACC_W-1:0] seg;
            logic [ACC_W-1:0] ae;
            logic [ACC_W-1:0] mag;
            logic [ACC_W-1:0] pat;
            logic [ACC_W-1:0] loc;
            logic             blo;
            logic             bmid;
            logic             bhi;
            logic             one;
            logic             two;
            logic             hot_now;
            k    = (2 * i) / lw;
            j    = i - k * ndl;
            base = 2 * lw * k;
            // Sign-extended multiplicand of this row's lane.
            seg  = {{(ACC_W-DATA_W){1'b0}}, a} >> (lw * k);
            ae   = (seg & ones_l) | ({ACC_W{seg[lw-1]}} & ~ones_l);
            // Booth digit; the first digit of a lane sees a zero below it.
            blo  = (j == 0) ? 1'b0 : b_ext[2*i];
            bmid = b_ext[2*i+1];
            bhi  = b_ext[2*i+2];
            one  = bmid ^ blo;
            two  = (bhi & ~bmid & ~blo) | (~bhi & bmid & blo);
            mag  = one ? ae : (two ? (ae << 1) : '0);
            hot_now = 1'b0;
            if (j == ndl - 1) begin
                // Top row of a lane: exact negation, sign at bit lw+1.
                pat = bhi ? (~mag + ACC_W'(1)) : mag;
                loc = (pat & ((ones_l << 1) | ACC_W'(1)))
                    | ({{(ACC_W-1){1'b0}}, ~pat[lw+1]} << (lw + 1));
            end else begin
                // Inverted multiple; its +1 goes into the next row.
                pat     = bhi ? ~mag : mag;
                hot_now = bhi;
                if (j == 0)
                    loc = (pat & ones_l)
                        | (pat[lw] ? cst : (cst + (ACC_W'(1) << lw)));
                else
                    loc = (pat & ones_l)
                        | ({{(ACC_W-1){1'b0}}, ~pat[lw]} << lw);
            end
            loc = loc << (2 * j);
            if (j != 0)
                loc = loc | ({{(ACC_W-1){1'b0}}, hot_prev} << (2 * j - 2));
            // Mask to the lane's product field, then place the field.
            rows[i]  = (loc & fmask) << base;
            hot_prev = hot_now;
        end
    end

endmodule

// File: rtl/smac_seg_adder.sv
module smac_seg_adder
    import simd_mac_pkg::*;
#(
    parameter int NOPS = 2
) (
    input  logic [NOPS-1:0][ACC_W-1:0] ops,
    input  logic [1:0]                 mode,
    output logic [ACC_W-1:0]           sum
);

    localparam int CRY_W = $clog2(NOPS) + 1;
    localparam int PW    = SEG_W + CRY_W;

    always_comb begin
        logic [CRY_W-1:0] carry;
        int               lw;
        lw    = lane_bits(mode);
        carry = '0;
        sum   = '0;
        for (int c = 0; c < NSEG; c++) begin
            logic [PW-1:0] part;
            // A segment that starts a lane field takes no carry.
            if ((c * SEG_W) % (2 * lw) == 0)
                part = '0;
            else
                part = PW'(carry);
            for (int n = 0; n < NOPS; n++)
                part = part + PW'(ops[n][c*SEG_W +: SEG_W]);
            sum[c*SEG_W +: SEG_W] = part[SEG_W-1:0];
            carry = part[PW-1:SEG_W];
        end
    end

endmodule

// File: rtl/simd_mac.sv
module simd_mac
    import simd_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              clear,
    input  logic              acc_en,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [ACC_W-1:0]  acc_out
);

    pipe_state_e             st_q;
    pipe_state_e             st_d;
    logic [DATA_W-1:0]       a_q;
    logic [DATA_W-1:0]       b_q;
    logic [1:0]              mode_q;
    logic                    acc_en_q;
    logic [ACC_W-1:0]        acc_q;
    logic [NDIG-1:0][ACC_W-1:0] pp_rows;
    logic [ACC_W-1:0]        product;
    logic [1:0][ACC_W-1:0]   acc_ops;
    logic [ACC_W-1:0]        acc_next;

    // Next-state logic of the issue register.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  st_d = (op_valid && !clear) ? ST_LOADED : ST_EMPTY;
            ST_LOADED: st_d = (op_valid && !clear) ? ST_LOADED : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_EMPTY;
        else
            st_q <= st_d;
    end

    // Operation capture: operands and per-operation control.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            mode_q   <= MODE_X32;
            acc_en_q <= 1'b0;
        end else if (op_valid) begin
            a_q      <= opa;
            b_q      <= opb;
            mode_q   <= mode;
            acc_en_q <= acc_en;
        end
    end

    smac_booth_array u_booth (
        .a    (a_q),
        .b    (b_q),
        .mode (mode_q),
        .rows (pp_rows)
    );

    smac_seg_adder #(.NOPS(NDIG)) u_pp_sum (
        .ops  (pp_rows),
        .mode (mode_q),
        .sum  (product)
    );

    assign acc_ops[0] = product;
    assign acc_ops[1] = acc_en_q ? acc_q : '0;

    smac_seg_adder #(.NOPS(2)) u_acc_sum (
        .ops  (acc_ops),
        .mode (mode_q),
        .sum  (acc_next)
    );

    // Output register, driven by the issue state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (st_q == ST_LOADED)
            acc_q <= acc_next;
    end

    assign acc_out = acc_q;

endmodule

// File: rtl/simd_mac_chk.sv
module simd_mac_chk
    import simd_mac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              clear,
    input logic              acc_en,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [ACC_W-1:0]  acc_out
);

    logic              ld32_q;
    logic              ld16_q;
    logic              ldrsv_q;
    logic [ACC_W-1:0]  exp32_q;
    logic [ACC_W-1:0]  exp16_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld32_q  <= 1'b0;
            ld16_q  <= 1'b0;
            ldrsv_q <= 1'b0;
            exp32_q <= '0;
            exp16_q <= '0;
        end else begin
            ld32_q  <= op_valid && !clear && !acc_en && (mode == 2'b00);
            ld16_q  <= op_valid && !clear && !acc_en && (mode == 2'b01);
            ldrsv_q <= op_valid && !clear && !acc_en && (mode == 2'b11);
            exp32_q <= ACC_W'($signed(opa) * $signed(opb));
            exp16_q <= {32'($signed(opa[31:16]) * $signed(opb[31:16])),
                        32'($signed(opa[15:0])  * $signed(opb[15:0]))};
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (acc_out == '0));

    p_load32_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld32_q && !clear) |=> (acc_out == $past(exp32_q)));

    p_load16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld16_q && !clear) |=> (acc_out == $past(exp16_q)));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_out == '0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(op_valid) && !clear) |=> $stable(acc_out));

    p_rsv_as_x32_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ldrsv_q && !clear) |=> (acc_out == $past(exp32_q)));

endmodule

bind simd_mac simd_mac_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .clear    (clear),
    .acc_en   (acc_en),
    .mode     (mode),
    .opa      (opa),
    .opb      (opb),
    .acc_out  (acc_out)
);

// File: tb/simd_mac_bench.sv
module simd_mac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        clear = 1'b0;
    logic        acc_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [63:0] acc_out;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic [63:0] model = '0;

    always #4 clk = ~clk;

    simd_mac u_simd_mac (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .clear(clear),
        .acc_en(acc_en), .mode(mode), .opa(opa), .opb(opb), .acc_out(acc_out)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected under 20000", cyc);
            finish_run();
        end
    end

    function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, logic [1:0] m);
        logic [63:0] r;
        r = '0;
        case (m)
            2'b01: for (int k = 0; k < 2; k++)
                       r[32*k +: 32] = 32'($signed(a[16*k +: 16]) * $signed(b[16*k +: 16]));
            2'b10: for (int k = 0; k < 4; k++)
                       r[16*k +: 16] = 16'($signed(a[8*k +: 8]) * $signed(b[8*k +: 8]));
            default: r = 64'($signed(a) * $signed(b));
        endcase
        return r;
    endfunction

    function automatic logic [63:0] ref_add(logic [63:0] x, logic [63:0] y, logic [1:0] m);
        logic [63:0] r;
        case (m)
            2'b01: for (int k = 0; k < 2; k++)
                       r[32*k +: 32] = x[32*k +: 32] + y[32*k +: 32];
            2'b10: for (int k = 0; k < 4; k++)
                       r[16*k +: 16] = x[16*k +: 16] + y[16*k +: 16];
            default: r = x + y;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One operation: present at a negedge, result after the second rising edge.
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b,
                          logic [1:0] m, logic en);
        @(negedge clk);
        opa = a; opb = b; mode = m; acc_en = en; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        model = en ? ref_add(model, ref_prod(a, b, m), m) : ref_prod(a, b, m);
        check(req, acc_out, model);
    endtask

    task automatic t_reset();
        @(negedge clk);
        op_valid = 1'b1; opa = 32'h7FFF_FFFF; opb = 32'h7FFF_FFFF;
        repeat (3) @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", acc_out, 64'h0);
    endtask

    task automatic t_mode32();
        run_op("R2 corner -2^31*-2^31", 32'h8000_0000, 32'h8000_0000, 2'b00, 1'b0);
        run_op("R2 corner -2^31*max", 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1'b0);
        run_op("R2 -1*-1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1'b0);
        for (int n = 0; n < 40; n++)
            run_op("R2 random", $urandom(), $urandom(), 2'b00, 1'b0);
    endtask

    task automatic t_mode16();
        run_op("R3 corner -32768", 32'h8000_8000, 32'h8000_7FFF, 2'b01, 1'b0);
        run_op("R3 mixed signs", 32'h7FFF_8001, 32'hFFFF_8000, 2'b01, 1'b0);
        for (int n = 0; n < 40; n++)
            run_op("R3 random", $urandom(), $urandom(), 2'b01, 1'b0);
    endtask

    task automatic t_mode8();
        run_op("R4 corner -128", 32'h8080_8080, 32'h807F_8001, 2'b10, 1'b0);
        run_op("R4 ones", 32'hFF01_7FFF, 32'hFFFF_8080, 2'b10, 1'b0);
        for (int n = 0; n < 40; n++)
            run_op("R4 random", $urandom(), $urandom(), 2'b10, 1'b0);
    endtask

    task automatic t_isolation();
        run_op("R5 byte lane1 only", 32'h0000_8000, 32'h0000_8000, 2'b10, 1'b0);
        check("R5 byte neighbours zero", {acc_out[63:32], acc_out[15:0]}, 48'h0);
        run_op("R5 byte lane2 only", 32'h0080_0000, 32'h0080_0000, 2'b10, 1'b0);
        check("R5 byte lane2 value", acc_out, 64'h0000_4000_0000_0000);
        run_op("R5 half lane0 only", 32'h0000_8000, 32'h0000_8000, 2'b01, 1'b0);
        check("R5 half lane0 value", acc_out, 64'h0000_0000_4000_0000);
        run_op("R5 half lane1 -1 lane0 0", 32'hFFFF_0000, 32'h0001_1234, 2'b01, 1'b0);
        check("R5 half lane1 value", acc_out, 64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_accum();
        run_op("R6 byte load", 32'h8080_8080, 32'h8080_8080, 2'b10, 1'b0);
        for (int n = 0; n < 3; n++)
            run_op("R6 byte accumulate", 32'h8080_8080, 32'h8080_8080, 2'b10, 1'b1);
        check("R6 byte wrap to zero", acc_out, 64'h0);
        run_op("R6 word load", 32'h8000_0000, 32'h8000_0000, 2'b00, 1'b0);
        for (int n = 0; n < 3; n++)
            run_op("R6 word accumulate", 32'h8000_0000, 32'h8000_0000, 2'b00, 1'b1);
        check("R6 word wrap to zero", acc_out, 64'h0);
        run_op("R6 half lane0 negative", 32'h7FFF_0001, 32'h7FFF_FFFF, 2'b01, 1'b0);
        run_op("R6 half no carry across", 32'h0000_0001, 32'h0000_0001, 2'b01, 1'b1);
        for (int n = 0; n < 10; n++)
            run_op("R6 random accumulate", $urandom(), $urandom(), 2'(n % 3), 1'b1);
    endtask

    task automatic t_clear();
        run_op("R7 setup", 32'h1234_5678, 32'h0FED_CBA9, 2'b00, 1'b0);
        @(negedge clk);
        opa = 32'h7FFF_FFFF; opb = 32'h7FFF_FFFF; mode = 2'b00; acc_en = 1'b1;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; clear = 1'b1;
        @(negedge clk);
        check("R7 clear with held op", acc_out, 64'h0);
        op_valid = 1'b1;
        @(negedge clk);
        clear = 1'b0; op_valid = 1'b0;
        @(negedge clk);
        check("R7 op with clear dropped", acc_out, 64'h0);
        model = '0;
    endtask

    task automatic t_hold();
        run_op("R8 setup", 32'h0001_0203, 32'h0405_0607, 2'b10, 1'b0);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            opa = $urandom(); opb = $urandom(); mode = 2'(n); acc_en = n[0];
        end
        @(negedge clk);
        check("R8 idle hold", acc_out, model);
    endtask

    task automatic t_reserved();
        run_op("R9 reserved corner", 32'h8000_0000, 32'h8000_0001, 2'b11, 1'b0);
        check("R9 reserved as x32", acc_out, ref_prod(32'h8000_0000, 32'h8000_0001, 2'b00));
        run_op("R9 reserved random", 32'h8765_4321, 32'h1357_9BDF, 2'b11, 1'b0);
    endtask

    task automatic t_backtoback();
        logic [31:0] a1 = 32'h8081_7F01;
        logic [31:0] b1 = 32'h80FF_7F80;
        logic [31:0] a2 = 32'h8001_7FFF;
        logic [31:0] b2 = 32'hFFFF_8000;
        @(negedge clk);
        opa = a1; opb = b1; mode = 2'b10; acc_en = 1'b0; op_valid = 1'b1;
        @(negedge clk);
        opa = a2; opb = b2; mode = 2'b01; acc_en = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        model = ref_prod(a1, b1, 2'b10);
        check("R10 first op own mode", acc_out, model);
        @(negedge clk);
        model = ref_add(model, ref_prod(a2, b2, 2'b01), 2'b01);
        check("R10 second op own mode", acc_out, model);
    endtask

    initial begin
        t_reset();
        t_mode32();
        t_mode16();
        t_mode8();
        t_isolation();
        t_accum();
        t_clear();
        t_hold();
        t_reserved();
        t_backtoback();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule